// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Buffered Error Status

This block receives asynchronous serial characters: one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A 16x oversampling enable paces the receiver, and each bit is sampled at its middle. Each finished character goes into a two-entry receive queue. The framing and parity status of each character is stored with it in the queue.

Software reads the head of the queue through a read strobe. Three sticky error flags record framing, parity and overrun events. A framing or parity flag rises only when the bad character reaches the head of the queue and can be read, not when its stop bit arrives. An overrun happens when a character completes while both entries are full. In that case the new character is discarded. Each flag can be cleared by writing 1 to it and has its own interrupt enable. The interrupt output is the OR of the enabled flags.

Top module: `uart_rx_errq`

## Requirements
- R1: With `tick16` pulsing once per 1/16 bit time, a frame of start bit 0, eight data bits (LSB first), optional parity and stop bit 1 is received. Its byte then appears on `rd_data` with `empty` deasserted.
- R2: A low level on `rxd` that is high again at the middle of the start bit (8 ticks after the falling edge is seen) is discarded. No character is stored.
- R3: The queue holds two characters and reads them back in arrival order. `full` is set while two are held and `empty` while none are held. A `rd_stb` cycle removes the head. A `rd_stb` while empty has no effect.
- R4: If a character completes while two entries are held and no read happens in that cycle, the character is dropped. Flag bit 2 (overrun) is set and both stored characters stay unchanged.
- R5: A stop bit sampled as 0 marks the character with a framing error (`rd_fe`). The character is still stored. The receiver looks for the next start bit only after `rxd` returns high.
- R6: With `par_en`=1 a parity bit follows the data. `par_odd`=0 expects an even count of ones over the data and parity bits, and `par_odd`=1 expects an odd count. A mismatch marks the character with a parity error (`rd_pe`). With `par_en`=0 no parity bit is expected and no parity error is raised.
- R7: Flag bit 0 (framing) and flag bit 1 (parity) are set in the cycle after an errored character becomes the head. If the queue was empty, that is the cycle after it is stored. If it was stored behind another character, that is the cycle after the earlier character is read.
- R8: `flags` bits are 0 framing, 1 parity and 2 overrun. Each bit stays set until a cycle with the same bit of `flag_clr` at 1. A set event in the same cycle takes priority over the clear.
- R9: `irq` is 1 exactly when some bit is set in both `flags` and `irq_en`.
- R10: After reset the queue is empty, all flags are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_stb | input | 1 | Removes the head character |
| rd_data | output | 8 | Head character data |
| rd_fe | output | 1 | Head character had a framing error |
| rd_pe | output | 1 | Head character had a parity error |
| empty | output | 1 | Queue holds no character |
| full | output | 1 | Queue holds two characters |
| flags | output | 3 | Sticky flags: 0 framing, 1 parity, 2 overrun |
| flag_clr | input | 3 | Write-1 clear, one bit per flag |
| irq_en | input | 3 | Interrupt enable, one bit per flag |
| irq | output | 1 | OR of enabled flags |

## Verification
The assertions assume that `tick16` is a single-cycle pulse and that `rxd` keeps each bit level for a full 16 ticks. Under those conditions each bit is sampled once and completion pulses are isolated. The stimulus divides the clock by four to make the tick and holds every serial bit for 64 cycles. It changes `rxd`, `rd_stb` and `flag_clr` only on the falling clock edge. Read and clear strobes last one cycle. They are placed so that no character completes in the same cycle, except where a test aims at that case.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int DATA_W = 8;
    localparam int NFLAG  = 3;
    localparam int FLG_FE = 0;
    localparam int FLG_PE = 1;
    localparam int FLG_OV = 2;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fe;
        logic              pe;
    } rx_entry_t;
endpackage

// File: rtl/rx_shifter.sv
module rx_shifter
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick16,
    input  logic      rxd,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      done,
    output rx_entry_t chr
);
    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);
    localparam logic [TW-1:0] T_LAST = TW'(OSR - 1);
    localparam logic [TW-1:0] T_HALF = TW'(OSR / 2 - 1);
    localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         st;
        logic [TW-1:0]     tcnt;
        logic [BW-1:0]     bcnt;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic              done;
        rx_entry_t         chr;
    } sh_state_t;

    sh_state_t q, d;
    logic      rx;

    assign rx = q.sync[1];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.sync = {q.sync[0], rxd};
        if (q.st == RX_WAITHI) begin
            if (rx) d.st = RX_IDLE;
        end else if (tick16) begin
            case (q.st)
                RX_IDLE: begin
                    if (!rx) begin
                        d.st   = RX_START;
                        d.tcnt = '0;
                    end
                end
                RX_START: begin
                    if (q.tcnt == T_HALF) begin
                        d.tcnt = '0;
                        d.bcnt = '0;
                        d.st   = rx ? RX_IDLE : RX_DATA;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.tcnt == T_LAST) begin
                        d.tcnt = '0;
                        d.sh   = {rx, q.sh[DATA_W-1:1]};
                        if (q.bcnt == B_LAST) d.st = par_en ? RX_PAR : RX_STOP;
                        else                  d.bcnt = q.bcnt + 1'b1;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (q.tcnt == T_LAST) begin
                        d.tcnt = '0;
                        d.pbit = rx;
                        d.st   = RX_STOP;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.tcnt == T_LAST) begin
                        d.tcnt     = '0;
                        d.done     = 1'b1;
                        d.chr.data = q.sh;
                        d.chr.fe   = ~rx;
                        d.chr.pe   = par_en & ((^q.sh) ^ q.pbit ^ par_odd);
                        d.st       = rx ? RX_IDLE : RX_WAITHI;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
            q.st   <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign chr  = q.chr;

    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_waithi_after_fe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chr.fe) |-> (q.st == RX_WAITHI || rx));
    assert_no_pe_unless_par_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_en && d.done) |=> !chr.pe);
endmodule

// File: rtl/rx_fifo2.sv
module rx_fifo2
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  rx_entry_t wr_chr,
    input  logic      rd,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      head_new,
    output logic      head_new_fe,
    output logic      head_new_pe,
    output logic      ovr
);
    localparam int DEPTH = 2;

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [1:0]            cnt;
    } fifo_state_t;

    fifo_state_t q, d;
    logic        do_rd, do_wr;
    logic [1:0]  c1;

    always_comb begin
        d     = q;
        do_rd = rd && (q.cnt != 2'd0);
        do_wr = wr && ((q.cnt != 2'(DEPTH)) || do_rd);
        ovr   = wr && !do_wr;
        c1    = q.cnt - {1'b0, do_rd};
        if (do_rd) d.mem[0] = q.mem[1];
        if (do_wr) d.mem[c1[0]] = wr_chr;
        d.cnt = c1 + {1'b0, do_wr};
        head_new = (do_rd && q.cnt == 2'd2) || (do_wr && c1 == 2'd0);
    end

    assign head_new_fe = d.mem[0].fe;
    assign head_new_pe = d.mem[0].pe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[0];
    assign empty = (q.cnt == 2'd0);
    assign full  = (q.cnt == 2'(DEPTH));

    assert_overrun_keeps_entries_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> (full && q.mem[0].data == $past(q.mem[0].data)
                      && q.mem[1].data == $past(q.mem[1].data)));
    assert_rd_empty_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && empty && !wr) |=> empty);
    assert_order_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && full && !wr) |=> (!full && head.data == $past(q.mem[1].data)));
endmodule

// File: rtl/rx_flags.sv
module rx_flags
    import uart_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_new,
    input  logic             head_new_fe,
    input  logic             head_new_pe,
    input  logic             ovr,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] ien,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] flag_d, flag_q;

    always_comb begin
        set_v         = '0;
        set_v[FLG_FE] = head_new & head_new_fe;
        set_v[FLG_PE] = head_new & head_new_pe;
        set_v[FLG_OV] = ovr;
        flag_d        = (flag_q & ~clr) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;
    assign irq   = |(flag_q & ien);

    assert_ovr_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> flags[FLG_OV]);
    assert_fe_on_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (head_new && head_new_fe) |=> flags[FLG_FE]);
    assert_pe_on_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (head_new && head_new_pe) |=> flags[FLG_PE]);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_PE] && !clr[FLG_PE]) |=> flags[FLG_PE]);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[FLG_FE] && !(head_new && head_new_fe)) |=> !flags[FLG_FE]);
endmodule

// File: rtl/uart_rx_errq.sv
module uart_rx_errq
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fe,
    output logic              rd_pe,
    output logic              empty,
    output logic              full,
    output logic [NFLAG-1:0]  flags,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic [NFLAG-1:0]  irq_en,
    output logic              irq
);
    logic      done, head_new, head_new_fe, head_new_pe, ovr;
    rx_entry_t chr, head;

    rx_shifter #(.OSR(OSR)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .done(done), .chr(chr)
    );

    rx_fifo2 u_fifo (
        .clk(clk), .rst_n(rst_n), .wr(done), .wr_chr(chr), .rd(rd_stb),
        .head(head), .empty(empty), .full(full), .head_new(head_new),
        .head_new_fe(head_new_fe), .head_new_pe(head_new_pe), .ovr(ovr)
    );

    rx_flags u_flags (
        .clk(clk), .rst_n(rst_n), .head_new(head_new), .head_new_fe(head_new_fe),
        .head_new_pe(head_new_pe), .ovr(ovr), .clr(flag_clr), .ien(irq_en),
        .flags(flags), .irq(irq)
    );

    assign rd_data = head.data;
    assign rd_fe   = head.fe;
    assign rd_pe   = head.pe;

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & irq_en) != '0));
endmodule

// File: tb/sim_uart_rx_errq.sv
module sim_uart_rx_errq;
    logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
    logic       par_en = 1'b0, par_odd = 1'b0, rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_fe, rd_pe, empty, full, irq;
    logic [2:0] flags, flag_clr = '0, irq_en = '0;
    logic [1:0] div = '0;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        div    <= div + 2'd1;
        tick16 <= (div == 2'd3);
    end

    uart_rx_errq u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .par_en(par_en),
        .par_odd(par_odd), .rd_stb(rd_stb), .rd_data(rd_data), .rd_fe(rd_fe),
        .rd_pe(rd_pe), .empty(empty), .full(full), .flags(flags),
        .flag_clr(flag_clr), .irq_en(irq_en), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        repeat (64) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] v, input logic use_p,
                              input logic pbit, input logic stopb);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        if (use_p) send_bit(pbit);
        send_bit(stopb);
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_clear(input logic [2:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 empty", empty, 1);
        check("R10 flags", flags, 0);
        check("R10 irq", irq, 0);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 0, 0, 1);
        check("R1 data", rd_data, 8'hA5);
        check("R1 not empty", empty, 0);
        send_frame(8'h3C, 0, 0, 1);
        check("R3 full", full, 1);
        check("R3 head first", rd_data, 8'hA5);
        do_read();
        check("R3 order", rd_data, 8'h3C);
        do_read();
        check("R3 empty", empty, 1);
        do_read();
        check("R3 read empty ignored", empty, 1);
        check("R6 no pe without parity", flags, 0);
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        repeat (20) @(negedge clk);
        rxd = 1'b1;
        repeat (160) @(negedge clk);
        check("R2 glitch rejected", empty, 1);
    endtask

    task automatic t_parity();
        par_en = 1'b1;
        par_odd = 1'b0;
        send_frame(8'h07, 1, ^8'h07, 1);
        check("R6 even ok", {rd_data, rd_pe}, {8'h07, 1'b0});
        do_read();
        par_odd = 1'b1;
        send_frame(8'h07, 1, ~^8'h07, 1);
        check("R6 odd ok", {rd_data, rd_pe}, {8'h07, 1'b0});
        check("R6 no flag", flags[1], 0);
        do_read();
        par_odd = 1'b0;
        send_frame(8'h5A, 1, ~^8'h5A, 1);
        check("R6 even bad", rd_pe, 1);
        check("R7 pe flag when empty", flags[1], 1);
        do_read();
        do_clear(3'b010);
        check("R8 clear pe", flags[1], 0);
    endtask

    task automatic t_headflag();
        par_en = 1'b1;
        par_odd = 1'b0;
        send_frame(8'h11, 1, ^8'h11, 1);
        send_frame(8'h22, 1, ~^8'h22, 1);
        check("R7 pe held behind head", flags[1], 0);
        check("R7 head clean", rd_pe, 0);
        do_read();
        check("R7 pe at head", {rd_data, rd_pe, flags[1]}, {8'h22, 1'b1, 1'b1});
        do_read();
        do_clear(3'b010);
        par_en = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'hC3, 0, 0, 0);
        check("R5 stored", {empty, rd_data, rd_fe}, {1'b0, 8'hC3, 1'b1});
        check("R7 fe flag", flags[0], 1);
        do_read();
        send_frame(8'h96, 0, 0, 1);
        check("R5 next frame ok", {rd_data, rd_fe}, {8'h96, 1'b0});
        do_read();
        check("R8 fe sticky", flags[0], 1);
        do_clear(3'b001);
        check("R8 fe cleared", flags[0], 0);
    endtask

    task automatic t_overrun();
        send_frame(8'h01, 0, 0, 1);
        send_frame(8'h02, 0, 0, 1);
        check("R4 no ovr yet", flags[2], 0);
        send_frame(8'h03, 0, 0, 1);
        check("R4 ovr flag", flags[2], 1);
        check("R4 head kept", {full, rd_data}, {1'b1, 8'h01});
        do_read();
        check("R4 second kept", rd_data, 8'h02);
        do_read();
        check("R4 dropped", empty, 1);
    endtask

    task automatic t_irq();
        irq_en = 3'b001;
        @(negedge clk);
        check("R9 masked", irq, 0);
        irq_en = 3'b100;
        @(negedge clk);
        check("R9 enabled", irq, 1);
        do_clear(3'b100);
        check("R9 cleared", {flags, irq}, {3'b000, 1'b0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_glitch();
        t_parity();
        t_headflag();
        t_framing();
        t_overrun();
        t_irq();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule